// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable synchronous static RAM whose address, write data, chip selects and burst and write controls are captured on the rising clock edge. Reads are flow-through: the word at the captured address leaves the array in the same clock period, with no output register in between. The shared data bus is split into an input vector, an output vector and an output-drive flag.

A four-beat burst is opened by either of two start strobes. One start strobe is for a processor and is honoured only while the first chip select is active. The other start strobe is for a cache or memory controller. The low two address bits then come from a 2-bit beat counter. That counter steps only in cycles where the advance input is low. It follows either linear order (start plus count, wrapping) or interleaved order (start XOR count). The order is captured when the burst opens, and a low level on the mode pin selects interleaved order, as with an unconnected strap. Writes go either to the selected byte lanes or, with global write, to every lane. The output enable and the sleep input act without a clock. While sleep is high, no clock edge has any effect.

The controller is a three-state machine. ST_IDLE is deselected and drives nothing. ST_READ is a selected read beat. ST_WRITE is a selected write beat. The transitions are:
- LOAD_SEL: a start strobe with all selects true enters ST_READ or ST_WRITE.
- LOAD_DESEL: a start strobe with any select false enters ST_IDLE.
- CONTINUE: with no start strobe, ST_READ or ST_WRITE goes to ST_WRITE if a write is requested and otherwise to ST_READ, stepping the counter when the advance input is low.
- STAY_IDLE: ST_IDLE without a start strobe stays in ST_IDLE.
- SLEEP_HOLD: any state while sleep is high stays where it is.

Top module: `sburst_sram`

## Requirements
- R1: The part is selected only when cs1_n is 0, cs2 is 1 and cs3_n is 0 at a start strobe. A start strobe with any select false enters ST_IDLE, and ST_IDLE drives no output until the next selected start.
- R2: Reads are flow-through. After the edge that captures a read at address A, d_out carries the word at A in that same clock period.
- R3: With burst_linear = 1 at the start, the low two address bits on beat k are (start + k) mod 4. The higher bits stay fixed, and a fifth step wraps back to the start address.
- R4: With burst_linear = 0 at the start, the low two address bits on beat k are start XOR k.
- R5: The beat counter steps only at edges where adv_n = 0. With adv_n = 1 and no start strobe, the address is held.
- R6: cpu_start_n = 0 while cs1_n = 0 loads a new address and always makes a read, and all write controls are ignored on that edge. While cs1_n = 1, cpu_start_n has no effect.
- R7: ctl_start_n = 0 loads a new address. The beat is a write if write controls are asserted on that edge, and otherwise a read.
- R8: With wr_all_n = 1 and wr_byte_n = 0, only the lanes whose lane_n bit is 0 are written. Lane i is d_in[9i+8:9i]. With no lane bit low, the beat is a read.
- R9: wr_all_n = 0 writes all four lanes, whatever wr_byte_n and lane_n are.
- R10: d_oe is 1 only in ST_READ with oe_n = 0 and sleep = 0. oe_n acts without a clock edge.
- R11: While sleep = 1, clock edges change neither the state, the address nor the memory, and d_oe is 0 at once. After sleep falls, the previous read reappears.
- R12: After reset the controller is in ST_IDLE and d_oe is 0.
- R13: A new address may be loaded on every edge with no idle cycle. A write is readable on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| addr | input | ADDR_W | Word address, captured at a start strobe |
| d_in | input | LANES*LANE_W | Write data, captured on write edges |
| d_out | output | LANES*LANE_W | Flow-through read data |
| d_oe | output | 1 | High when d_out should drive the bus |
| cs1_n | input | 1 | Chip select 1, active low, also gates cpu_start_n |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| cpu_start_n | input | 1 | Processor-side burst start, active low |
| ctl_start_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| burst_linear | input | 1 | 1 selects linear order, 0 selects interleaved |
| oe_n | input | 1 | Output enable, active low, no clock needed |
| sleep | input | 1 | Power-down, active high, no clock needed |

## Verification
Several functions can fall on the same edge. A start strobe can arrive while a burst is still advancing. A processor start can come with write controls that it must ignore. Global write can be asserted together with a byte-write lane pattern. Sleep or a high oe_n can be asserted during a read beat with a start strobe and advance also pending. The bench drives each of these combinations on a single edge. It judges the winner against a behavioural model that applies the priority order in the requirements: sleep first, then selected start, then continuation. The model is compared with d_oe and d_out after every edge, and also right after each change to an input that acts without a clock.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } sbs_state_e;
endpackage

// File: rtl/sbs_order.sv
module sbs_order
    import sbs_pkg::*;
(
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    input  logic              linear,
    output logic [BEAT_W-1:0] low
);
    always_comb begin
        if (linear) begin
            low = start + beat;
        end else begin
            low = start ^ beat;
        end
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_mask[g]) begin
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              cpu_start_n,
    input  logic              ctl_start_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              burst_linear,
    output sbs_state_e        st_q,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_mask,
    output logic              lin_q
);
    localparam int HI_W = ADDR_W - BEAT_W;

    sbs_state_e        st_n;
    logic [HI_W-1:0]   hi_q, hi_n;
    logic [BEAT_W-1:0] start_q, start_n;
    logic [BEAT_W-1:0] cnt_q, cnt_n;
    logic              lin_n;
    logic [BEAT_W-1:0] cur_low, nxt_low;

    logic              selected;
    logic              load_cpu;
    logic              load_ctl;
    logic [LANES-1:0]  req_lanes;

    assign selected = !cs1_n && cs2 && !cs3_n;
    assign load_cpu = !cpu_start_n && !cs1_n;
    assign load_ctl = !ctl_start_n;
    assign req_lanes = !wr_all_n  ? {LANES{1'b1}} :
                       !wr_byte_n ? ~lane_n       : {LANES{1'b0}};

    sbs_order u_cur_order (
        .start  (start_q),
        .beat   (cnt_q),
        .linear (lin_q),
        .low    (cur_low)
    );

    sbs_order u_nxt_order (
        .start  (start_q),
        .beat   (cnt_n),
        .linear (lin_q),
        .low    (nxt_low)
    );

    assign rd_addr = {hi_q, cur_low};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
        end else begin
            st_q    <= st_n;
            hi_q    <= hi_n;
            start_q <= start_n;
            cnt_q   <= cnt_n;
            lin_q   <= lin_n;
        end
    end

    // next state and write strobe
    always_comb begin
        st_n    = st_q;
        hi_n    = hi_q;
        start_n = start_q;
        cnt_n   = cnt_q;
        lin_n   = lin_q;
        wr_mask = '0;
        wr_addr = rd_addr;
        if (!sleep) begin
            if (load_cpu || load_ctl) begin
                if (selected) begin
                    hi_n    = addr[ADDR_W-1:BEAT_W];
                    start_n = addr[BEAT_W-1:0];
                    cnt_n   = '0;
                    lin_n   = burst_linear;
                    wr_addr = addr;
                    if (!load_cpu && (|req_lanes)) begin
                        st_n    = ST_WRITE;
                        wr_mask = req_lanes;
                    end else begin
                        st_n    = ST_READ;
                    end
                end else begin
                    st_n = ST_IDLE;
                end
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        st_n = ST_IDLE;
                    end
                    ST_READ, ST_WRITE: begin
                        cnt_n   = adv_n ? cnt_q : cnt_q + 1'b1;
                        wr_addr = {hi_q, nxt_low};
                        wr_mask = req_lanes;
                        st_n    = (|req_lanes) ? ST_WRITE : ST_READ;
                    end
                    default: begin
                        st_n = ST_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] d_in,
    output logic [LANES*LANE_W-1:0] d_out,
    output logic                    d_oe,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    cpu_start_n,
    input  logic                    ctl_start_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    burst_linear,
    input  logic                    oe_n,
    input  logic                    sleep
);
    sbs_state_e        st_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [LANES-1:0]  wr_mask;
    logic              lin_q;

    sbs_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep        (sleep),
        .addr         (addr),
        .cs1_n        (cs1_n),
        .cs2          (cs2),
        .cs3_n        (cs3_n),
        .cpu_start_n  (cpu_start_n),
        .ctl_start_n  (ctl_start_n),
        .adv_n        (adv_n),
        .wr_all_n     (wr_all_n),
        .wr_byte_n    (wr_byte_n),
        .lane_n       (lane_n),
        .burst_linear (burst_linear),
        .st_q         (st_q),
        .rd_addr      (rd_addr),
        .wr_addr      (wr_addr),
        .wr_mask      (wr_mask),
        .lin_q        (lin_q)
    );

    sbs_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .wr_mask (wr_mask),
        .wr_addr (wr_addr),
        .wr_data (d_in),
        .rd_addr (rd_addr),
        .rd_data (d_out)
    );

    // output enable
    always_comb begin
        d_oe = (st_q == ST_READ) && !oe_n && !sleep;
    end
endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              cpu_start_n,
    input logic              ctl_start_n,
    input logic              adv_n,
    input logic              d_oe,
    input logic              lin_q,
    input sbs_state_e        st_q,
    input logic [ADDR_W-1:0] rd_addr
);
    logic any_start;
    logic sel_ok;
    assign any_start = (!cpu_start_n && !cs1_n) || !ctl_start_n;
    assign sel_ok    = !cs1_n && cs2 && !cs3_n;

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && any_start && !sel_ok) |=> !d_oe);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !any_start && st_q != ST_IDLE && adv_n) |=> $stable(rd_addr));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !any_start && st_q != ST_IDLE && !adv_n && lin_q)
        |=> (rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1)
            && (rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2])));

    // R6
    cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cpu_start_n && sel_ok) |=> st_q == ST_READ);

    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(st_q) && $stable(rd_addr));
endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep       (sleep),
    .cs1_n       (cs1_n),
    .cs2         (cs2),
    .cs3_n       (cs3_n),
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .adv_n       (adv_n),
    .d_oe        (d_oe),
    .lin_q       (lin_q),
    .st_q        (st_q),
    .rd_addr     (rd_addr)
);

// File: tb/tb_sburst_sram.sv
module tb_sburst_sram;
    localparam int CLK_P = 10;
    localparam int AW = 8;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] d_in;
    logic [DW-1:0] d_out;
    logic          d_oe;
    logic          cs1_n, cs2, cs3_n;
    logic          cpu_start_n, ctl_start_n, adv_n;
    logic          wr_all_n, wr_byte_n;
    logic [LN-1:0] lane_n;
    logic          burst_linear, oe_n, sleep;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    int m_state;
    int m_base;
    int m_cnt;
    bit m_lin;
    logic [DW-1:0] ref_mem [int];

    always #(CLK_P/2) clk = ~clk;

    sburst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .d_in(d_in), .d_out(d_out),
        .d_oe(d_oe), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .burst_linear(burst_linear), .oe_n(oe_n), .sleep(sleep)
    );

    function automatic int m_addr();
        int low;
        if (m_lin) low = (m_base + m_cnt) % 4;
        else       low = (m_base % 4) ^ m_cnt;
        return (m_base / 4) * 4 + low;
    endfunction

    function automatic logic [LN-1:0] m_lanes();
        if (!wr_all_n)  return {LN{1'b1}};
        if (!wr_byte_n) return ~lane_n;
        return '0;
    endfunction

    task automatic m_write(int a, logic [LN-1:0] wm);
        logic [DW-1:0] v;
        if (wm != '0) begin
            v = ref_mem.exists(a) ? ref_mem[a] : '0;
            for (int i = 0; i < LN; i++)
                if (wm[i]) v[i*LW +: LW] = d_in[i*LW +: LW];
            ref_mem[a] = v;
        end
    endtask

    task automatic m_edge();
        bit sel;
        bit ld_cpu;
        bit ld_ctl;
        logic [LN-1:0] wm;
        if (!rst_n) begin
            m_state = 0;
        end else if (!sleep) begin
            sel    = !cs1_n && cs2 && !cs3_n;
            ld_cpu = !cpu_start_n && !cs1_n;
            ld_ctl = !ctl_start_n;
            wm     = m_lanes();
            if (ld_cpu || ld_ctl) begin
                if (sel) begin
                    m_base = int'(addr);
                    m_cnt  = 0;
                    m_lin  = burst_linear;
                    if (!ld_cpu && wm != '0) begin
                        m_write(m_base, wm);
                        m_state = 2;
                    end else begin
                        m_state = 1;
                    end
                end else begin
                    m_state = 0;
                end
            end else if (m_state != 0) begin
                if (!adv_n) m_cnt = (m_cnt + 1) % 4;
                m_write(m_addr(), wm);
                m_state = (wm != '0) ? 2 : 1;
            end
        end
    endtask

    task automatic compare(string tag);
        bit exp_oe;
        int a;
        exp_oe = (m_state == 1) && !oe_n && !sleep;
        checks++;
        if (d_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s d_oe actual %b expected %b", tag, d_oe, exp_oe);
        end
        a = m_addr();
        if (m_state != 0 && ref_mem.exists(a)) begin
            checks++;
            if (d_out !== ref_mem[a]) begin
                errors++;
                $display("FAIL %s d_out actual %h expected %h", tag, d_out, ref_mem[a]);
            end
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        m_edge();
        #1;
        compare(tag);
    endtask

    task automatic quiet();
        cs1_n = 0; cs2 = 1; cs3_n = 0;
        cpu_start_n = 1; ctl_start_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = '1;
        oe_n = 0; sleep = 0;
    endtask

    initial begin
        rst_n = 0; addr = '0; d_in = '0; burst_linear = 1;
        m_state = 0; m_base = 0; m_cnt = 0; m_lin = 0;
        quiet();
        tick("R12");
        tick("R12");
        rst_n = 1;
        tick("R12");

        // R7 R9: controller-start global write burst, linear
        ctl_start_n = 0; addr = 8'h10; wr_all_n = 0; d_in = 36'h0_1111_1111;
        tick("R7");
        ctl_start_n = 1; adv_n = 0;
        d_in = 36'h2_2222_2222; tick("R9");
        d_in = 36'h3_3333_3333; tick("R9");
        d_in = 36'h4_4444_4444; tick("R9");

        // R6 R3 R5 R2: processor-start read, linear from 0x11
        quiet(); cpu_start_n = 0; addr = 8'h11; burst_linear = 1;
        tick("R2");
        cpu_start_n = 1; adv_n = 0;
        tick("R3"); tick("R3"); tick("R3"); tick("R3");
        adv_n = 1; tick("R5"); tick("R5");

        // R4: interleaved from 0x11
        quiet(); cpu_start_n = 0; addr = 8'h11; burst_linear = 0;
        tick("R4");
        cpu_start_n = 1; adv_n = 0;
        tick("R4"); tick("R4"); tick("R4");

        // R8: byte lanes 0 and 2
        quiet(); ctl_start_n = 0; addr = 8'h12; wr_byte_n = 0; lane_n = 4'b1010;
        d_in = 36'h1_FF55_AA77; tick("R8");
        quiet(); ctl_start_n = 0; addr = 8'h12; tick("R8");
        // R8: byte enable with no lane selected is a read
        quiet(); ctl_start_n = 0; addr = 8'h13; wr_byte_n = 0; lane_n = 4'b1111;
        d_in = 36'hF_0000_0000; tick("R8");

        // R9: global write overrides lane pattern
        quiet(); ctl_start_n = 0; addr = 8'h12; wr_all_n = 0; wr_byte_n = 0;
        lane_n = 4'b0111; d_in = 36'h9_8765_4321; tick("R9");
        quiet(); ctl_start_n = 0; addr = 8'h12; tick("R9");

        // R6: processor start ignores write controls
        quiet(); cpu_start_n = 0; addr = 8'h10; wr_all_n = 0; d_in = 36'hE_EEEE_EEEE;
        tick("R6");
        quiet(); ctl_start_n = 0; addr = 8'h10; tick("R6");
        // R6: processor strobe ignored while cs1_n high, burst continues
        quiet(); cpu_start_n = 0; cs1_n = 1; addr = 8'h30; adv_n = 0; tick("R6");

        // R1: deselection
        quiet(); ctl_start_n = 0; cs2 = 0; addr = 8'h10; tick("R1");
        quiet(); ctl_start_n = 0; cs3_n = 1; addr = 8'h10; tick("R1");
        quiet(); cpu_start_n = 0; cs3_n = 1; addr = 8'h10; tick("R1");
        quiet(); adv_n = 0; tick("R1");

        // R10: output enable without a clock
        quiet(); ctl_start_n = 0; addr = 8'h11; oe_n = 1; tick("R10");
        quiet(); oe_n = 0; #1; compare("R10");
        oe_n = 1; #1; compare("R10");
        oe_n = 0; sleep = 1; #1; compare("R11");

        // R11: sleep freezes everything
        ctl_start_n = 0; addr = 8'h20; wr_all_n = 0; adv_n = 0; d_in = 36'h5_5555_5555;
        tick("R11"); tick("R11");
        quiet(); #1; compare("R11");
        quiet(); ctl_start_n = 0; addr = 8'h20; tick("R11");

        // R13: back-to-back loads, write then read
        quiet(); burst_linear = 1;
        ctl_start_n = 0; addr = 8'h10; tick("R13");
        addr = 8'h13; tick("R13");
        addr = 8'h12; tick("R13");
        addr = 8'h21; wr_all_n = 0; d_in = 36'h6_789A_BCDE; tick("R13");
        wr_all_n = 1; tick("R13");

        // R3: wrap from 0x13
        quiet(); ctl_start_n = 0; addr = 8'h13; tick("R3");
        ctl_start_n = 1; adv_n = 0;
        tick("R3"); tick("R3"); tick("R3"); tick("R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule